// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator

This block collects a word of peripheral interrupt sources and merges them into one request line for a parent interrupt controller. A rising edge on any source is caught in a sticky status bit. The bit stays set until software acknowledges it. Each source also has a disable bit. The request line is high while at least one caught event is not disabled.

Software uses a small synchronous register bus. Status and mask each have a read view, a write-one-to-set address and a write-one-to-clear address. Because of this, software never needs a read-modify-write sequence. Software raises interrupts through the status-set address, acknowledges them through status-clear, and uses mask-set and mask-clear to disable or enable sources. The parent's handler reads status and mask and works out for itself which sources are pending.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status bit is 0 and every mask bit is 1 (all sources disabled), so `irq_o` is 0.
- R2: A 0-to-1 transition on `src_i[k]` sets status bit k. The bit stays set after the input falls. A level that stays high does not set the bit again once it has been cleared.
- R3: A write to byte offset 0x08 clears every status bit whose data bit is 1. Bits written as 0 are left as they are.
- R4: A write to byte offset 0x04 sets every status bit whose data bit is 1.
- R5: Mask bit k = 1 disables source k. A write to offset 0x10 sets the mask bits written as 1. A write to offset 0x14 clears the mask bits written as 1. The mask word reads back at offset 0x0C.
- R6: `irq_o` is 1 exactly when (status AND NOT mask) is non-zero. It reflects a register write in the cycle after the write.
- R7: Setting a mask bit does not change the status bit. A masked event that is later unmasked raises `irq_o`.
- R8: If a rising edge and a status-clear of the same bit fall in the same cycle, the bit ends up set.
- R9: A read at offset 0x00 returns status and a read at 0x0C returns mask. Reads at 0x04, 0x08, 0x10 and 0x14 return 0. `bus_rdata` is valid from the cycle after the read access and holds until the next read.
- R10: An access to any other offset, including offsets that are not word aligned, changes no state. A read there returns 0.
- R11: Writing all ones to mask-set disables every source and drops `irq_o`. Writing all ones to status-clear discards every caught event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | N_SRC | Peripheral interrupt sources, synchronous to clk, edge-detected |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data, registered |
| irq_o | output | 1 | Request toward the parent controller |

## Verification
On every cycle, the embedded assertions check the following: a caught edge is present in status on the next cycle, even against a clear; set and clear writes reach their bits; a mask write leaves status untouched; a fully masked word keeps `irq_o` low; and unmapped accesses leave status and mask stable. Some behaviours depend on sequences, so only the bench scenarios show them. These are: a high level that does not re-latch after an acknowledge, a masked event that reappears on unmask, the exact read-back values of each offset, and the reset state seen at the ports.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Byte offsets of the register views
  localparam int unsigned OFF_STAT     = 'h00;
  localparam int unsigned OFF_STAT_SET = 'h04;
  localparam int unsigned OFF_STAT_CLR = 'h08;
  localparam int unsigned OFF_MASK     = 'h0C;
  localparam int unsigned OFF_MASK_SET = 'h10;
  localparam int unsigned OFF_MASK_CLR = 'h14;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_STAT,
    RS_STAT_SET,
    RS_STAT_CLR,
    RS_MASK,
    RS_MASK_SET,
    RS_MASK_CLR
  } reg_sel_e;

endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] rise_o
);

  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] src_d;

  always_comb begin
    src_d = src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_rise
    assign rise_o[k] = src_i[k] & ~src_q[k];
  end

endmodule

// File: rtl/irqagg_regbus.sv
module irqagg_regbus
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic [N_SRC-1:0]  status_i,
  input  logic [N_SRC-1:0]  mask_i,
  output logic [N_SRC-1:0]  stat_set_o,
  output logic [N_SRC-1:0]  stat_clr_o,
  output logic [N_SRC-1:0]  mask_set_o,
  output logic [N_SRC-1:0]  mask_clr_o,
  output logic              unmapped_o,
  output logic [N_SRC-1:0]  rdata_o
);

  localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_STAT_SET = ADDR_W'(OFF_STAT_SET);
  localparam logic [ADDR_W-1:0] A_STAT_CLR = ADDR_W'(OFF_STAT_CLR);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(OFF_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(OFF_MASK_CLR);

  reg_sel_e         sel;
  logic             wr_en;
  logic             rd_en;
  logic [N_SRC-1:0] rdata_q;
  logic [N_SRC-1:0] rdata_d;

  // Address decode
  always_comb begin
    unique case (bus_addr)
      A_STAT:     sel = RS_STAT;
      A_STAT_SET: sel = RS_STAT_SET;
      A_STAT_CLR: sel = RS_STAT_CLR;
      A_MASK:     sel = RS_MASK;
      A_MASK_SET: sel = RS_MASK_SET;
      A_MASK_CLR: sel = RS_MASK_CLR;
      default:    sel = RS_NONE;
    endcase
  end

  assign wr_en      = bus_sel &  bus_wr;
  assign rd_en      = bus_sel & ~bus_wr;
  assign unmapped_o = bus_sel & (sel == RS_NONE);

  // Write strobes: data word gated by the decoded view
  assign stat_set_o = (wr_en && sel == RS_STAT_SET) ? bus_wdata : '0;
  assign stat_clr_o = (wr_en && sel == RS_STAT_CLR) ? bus_wdata : '0;
  assign mask_set_o = (wr_en && sel == RS_MASK_SET) ? bus_wdata : '0;
  assign mask_clr_o = (wr_en && sel == RS_MASK_CLR) ? bus_wdata : '0;

  // Read data next state: only the two read views return data
  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      unique case (sel)
        RS_STAT: rdata_d = status_i;
        RS_MASK: rdata_d = mask_i;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R9: write-only views read back as zero
  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == RS_STAT_SET || sel == RS_STAT_CLR ||
               sel == RS_MASK_SET || sel == RS_MASK_CLR)) |=> (rdata_o == '0));

  // R10: unmapped reads return zero
  a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped_o) |=> (rdata_o == '0));

  // R9: read data holds between reads
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_o));

  // At most one write view fires per cycle
  a_r3_single_view: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|stat_set_o, |stat_clr_o, |mask_set_o, |mask_clr_o}));

endmodule

// File: rtl/irqagg_core.sv
module irqagg_core #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] stat_set_i,
  input  logic [N_SRC-1:0] stat_clr_i,
  input  logic [N_SRC-1:0] mask_set_i,
  input  logic [N_SRC-1:0] mask_clr_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);

  logic [N_SRC-1:0] status_q, status_d;
  logic [N_SRC-1:0] mask_q,   mask_d;
  logic [N_SRC-1:0] pending;
  logic             status_en;
  logic             mask_en;

  assign status_en = |{rise_i, stat_set_i, stat_clr_i};
  assign mask_en   = |{mask_set_i, mask_clr_i};

  // Per-bit next state; a fresh edge outranks an acknowledge
  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    always_comb begin
      status_d[k] = (status_q[k] & ~stat_clr_i[k]) | stat_set_i[k] | rise_i[k];
      mask_d[k]   = (mask_q[k] | mask_set_i[k]) & ~mask_clr_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign pending  = status_q & ~mask_q;
  assign irq_o    = |pending;
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R2 / R8: a caught edge is present next cycle, whatever the bus does
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((status_o & $past(rise_i)) == $past(rise_i)));

  // R3: acknowledged bits without a new edge are cleared
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_clr_i & ~rise_i)) |=> ((status_o & $past(stat_clr_i & ~rise_i)) == '0));

  // R4: software-raised bits are set
  a_r4_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_set_i) |=> ((status_o & $past(stat_set_i)) == $past(stat_set_i)));

  // R5: mask set and mask clear land on their bits
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_set_i) |=> ((mask_o & $past(mask_set_i)) == $past(mask_set_i)));
  a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_clr_i) |=> ((mask_o & $past(mask_clr_i)) == '0));

  // R7: mask writes never discard caught events
  a_r7_mask_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && !status_en) |=> (status_o == $past(status_o)));

  // R11: full mask keeps the request low
  a_r11_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '1) |-> !irq_o);

  // R6: nothing caught, no request
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> !irq_o);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_o
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_int;
  logic [N_SRC-1:0]      rise;
  logic [N_SRC-1:0]      stat_set, stat_clr, mask_set, mask_clr;
  logic [N_SRC-1:0]      status, mask;
  logic                  unmapped;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[RST_STAGES-1];

  irqagg_edge #(.N_SRC(N_SRC)) i_edge (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irqagg_regbus #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) i_regbus (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status_i   (status),
    .mask_i     (mask),
    .stat_set_o (stat_set),
    .stat_clr_o (stat_clr),
    .mask_set_o (mask_set),
    .mask_clr_o (mask_clr),
    .unmapped_o (unmapped),
    .rdata_o    (bus_rdata)
  );

  irqagg_core #(.N_SRC(N_SRC)) i_core (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .rise_i     (rise),
    .stat_set_i (stat_set),
    .stat_clr_i (stat_clr),
    .mask_set_i (mask_set),
    .mask_clr_i (mask_clr),
    .status_o   (status),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  // R10: unmapped accesses leave all state alone
  a_r10_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n_int)
    (unmapped && rise == '0) |=> ($stable(status) && $stable(mask)));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  localparam int N  = 32;
  localparam int AW = 8;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2;
  localparam int NV = 33;

  // {op, addr, data, expected, requirement}
  localparam logic [77:0] VECS [NV] = '{
    {OP_R, 8'h0C, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 mask reset
    {OP_R, 8'h00, 32'h0, 32'h0,         4'd1},  // R1 status reset
    {OP_I, 8'h00, 32'h0, 32'h0,         4'd1},  // R1 no request
    {OP_W, 8'h04, 32'hA5, 32'h0,        4'd4},  // R4 raise
    {OP_R, 8'h00, 32'h0, 32'hA5,        4'd4},
    {OP_I, 8'h00, 32'h0, 32'h0,         4'd5},  // R5 masked
    {OP_W, 8'h14, 32'h4, 32'h0,         4'd5},
    {OP_I, 8'h00, 32'h0, 32'h1,         4'd6},  // R6
    {OP_R, 8'h0C, 32'h0, 32'hFFFF_FFFB, 4'd5},
    {OP_W, 8'h08, 32'h1, 32'h0,         4'd3},  // R3 ack bit 0
    {OP_R, 8'h00, 32'h0, 32'hA4,        4'd3},
    {OP_I, 8'h00, 32'h0, 32'h1,         4'd6},
    {OP_W, 8'h10, 32'h4, 32'h0,         4'd5},
    {OP_I, 8'h00, 32'h0, 32'h0,         4'd7},  // R7
    {OP_R, 8'h00, 32'h0, 32'hA4,        4'd7},
    {OP_W, 8'h14, 32'h4, 32'h0,         4'd7},
    {OP_I, 8'h00, 32'h0, 32'h1,         4'd7},
    {OP_W, 8'h08, 32'h4, 32'h0,         4'd3},
    {OP_I, 8'h00, 32'h0, 32'h0,         4'd6},
    {OP_R, 8'h04, 32'h0, 32'h0,         4'd9},  // R9
    {OP_R, 8'h08, 32'h0, 32'h0,         4'd9},
    {OP_W, 8'h18, 32'hFFFF_FFFF, 32'h0, 4'd10}, // R10
    {OP_R, 8'h0C, 32'h0, 32'hFFFF_FFFB, 4'd10},
    {OP_W, 8'h05, 32'hFFFF_FFFF, 32'h0, 4'd10},
    {OP_R, 8'h00, 32'h0, 32'hA0,        4'd10},
    {OP_R, 8'h18, 32'h0, 32'h0,         4'd10},
    {OP_W, 8'h14, 32'hFFFF_FFFF, 32'h0, 4'd5},
    {OP_R, 8'h0C, 32'h0, 32'h0,         4'd5},
    {OP_I, 8'h00, 32'h0, 32'h1,         4'd6},
    {OP_W, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd11}, // R11
    {OP_I, 8'h00, 32'h0, 32'h0,         4'd11},
    {OP_W, 8'h08, 32'hFFFF_FFFF, 32'h0, 4'd11},
    {OP_R, 8'h00, 32'h0, 32'h0,         4'd11}
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata, bus_rdata;
  logic          irq;

  int n_chk;
  int n_bad;
  bit done;

  irq_aggregator #(.N_SRC(N), .ADDR_W(AW)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rd;
    n_chk = 0; n_bad = 0; done = 1'b0;
    src = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    do_reset();

    // R1: request low right after reset
    check("R1", {31'b0, irq}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]   op;
      logic [7:0]   a;
      logic [31:0]  d, e;
      logic [3:0]   rq;
      string        tag;
      {op, a, d, e, rq} = VECS[v];
      tag = $sformatf("R%0d vec%0d", rq, v);
      case (op)
        OP_W: bus_write(a, d);
        OP_R: begin bus_read(a, rd); check(tag, rd, e); end
        default: begin @(negedge clk); check(tag, {31'b0, irq}, e); end
      endcase
    end

    // R2: pulse latches and holds after the input falls
    @(negedge clk); src[7] = 1'b1;
    repeat (2) @(negedge clk); src[7] = 1'b0;
    bus_read(8'h00, rd); check("R2 pulse held", rd, 32'h80);
    check("R2 masked no irq", {31'b0, irq}, 32'h0);
    bus_write(8'h14, 32'h80);
    check("R6 unmasked source", {31'b0, irq}, 32'h1);

    // R2: steady level does not re-latch after an acknowledge
    @(negedge clk); src[9] = 1'b1;
    bus_read(8'h00, rd); check("R2 level edge", rd, 32'h280);
    bus_write(8'h08, 32'h200);
    bus_read(8'h00, rd); check("R2 no relatch", rd, 32'h80);

    // R8: edge and acknowledge on the same bit in one cycle
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    bus_read(8'h00, rd); check("R2 bit3", rd, 32'h88);
    @(negedge clk);
    src[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h8;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(8'h00, rd); check("R8 edge wins", rd, 32'h88);
    bus_write(8'h08, 32'h8);
    bus_read(8'h00, rd); check("R3 ack without edge", rd, 32'h80);

    // R1: reset in the middle of activity
    @(negedge clk); src = '0;
    do_reset();
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(8'h00, rd); check("R1 status after reset", rd, 32'h0);
    bus_read(8'h0C, rd); check("R1 mask after reset", rd, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule